// File: doc/BRIEF.md
# Serial Converter Output Port Model

This block is a synthesizable stand-in for the digital side of a 20-bit serial analog-to-digital converter. It lets host reader logic be verified without an analog model. An internal timer divides the input clock to set the conversion rate, and a speed-select pin chooses between a slow and a fast divider. At each conversion boundary the block captures a wide signed sample. It saturates that sample to the 20-bit two's complement range and holds the result for the host.

A single output pin carries both the ready flag and the data. The pin rests high. It drops low when a fresh result is waiting. Each rising edge of the host serial clock then moves the next result bit onto the pin, starting with the most significant. After the twentieth bit, further serial clocks see the pin high. A result the host never reads is replaced at the next boundary.

The sample input and the speed-select pin are plain levels and have no handshake. The sample is read only in the cycle a conversion completes, so it applies no back-pressure. The serial clock is asynchronous to the input clock and is synchronized inside the block.

Top module: `adc_serial_port_model`

## Requirements
- R1: While reset is held, `dout_rdy` is high. The first conversion after reset always uses the slow divider, so `dout_rdy` first falls `DIV_SLOW` input clocks after reset is released.
- R2: With `rate_fast` low, successive falls of `dout_rdy` are `DIV_SLOW` input clocks apart.
- R3: With `rate_fast` high, successive falls of `dout_rdy` are `DIV_FAST` input clocks apart.
- R4: `rate_fast` is sampled only in the cycle a conversion completes. A change made just after a boundary leaves the next period at the old length and applies to the period after it.
- R5: Samples above +(2^19 - 1) give code 7FFFFh.
- R6: Samples below -(2^19) give code 80000h.
- R7: In-range samples give their own 20-bit two's complement value: 0 gives 00000h, +1 gives 00001h and -1 gives FFFFFh.
- R8: After ready, the n-th rising edge of `sclk` (n = 1..20) puts code bit 20-n on `dout_rdy`. The bit is visible by the third input-clock edge after the `sclk` rise, and the pin does not change without a `sclk` rise or a conversion boundary.
- R9: The 21st through 24th `sclk` rising edges, and any after them, leave `dout_rdy` high until the next conversion.
- R10: `dout_rdy` is high for exactly one input clock before each new result is latched. A result that has not been read is overwritten by the next conversion and reads back as the newer code.
- R11: Once low, `dout_rdy` stays low until the first `sclk` rising edge or the next conversion boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Converter master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_fast | input | 1 | Speed select: 0 gives the slow divider, 1 gives the fast divider |
| sample_in | input | SAMPLE_W | Signed sample captured at each conversion boundary |
| sclk | input | 1 | Host serial clock, asynchronous |
| dout_rdy | output | 1 | Combined ready (low) and serial data pin |

## Verification
A wrong conversion counter or latched divider shows at the ports as a wrong spacing between falls of `dout_rdy`, which is visible at the second fall after the fault. A slip in the bit counter or shift register corrupts the frame on the very next read. It shows up as a misplaced bit, a missing trailing one, or a pin that stays low past the twentieth clock. A wrong saturation bound shows only when a sample near full scale is read, so the vector table places entries on both sides of each bound.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;
  typedef enum logic [1:0] {
    PS_IDLE  = 2'd0,
    PS_READY = 2'd1,
    PS_SHIFT = 2'd2
  } port_state_t;
endpackage

// File: rtl/adc_rate_timer.sv
module adc_rate_timer #(
  parameter int DIV_SLOW = 491520,
  parameter int DIV_FAST = 61440
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rate_fast,
  output logic pre_done,
  output logic conv_done
);
  localparam int DIV_MAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
  localparam int CNT_W   = $clog2(DIV_MAX + 1);
  localparam logic [CNT_W-1:0] LIM_SLOW = CNT_W'(DIV_SLOW);
  localparam logic [CNT_W-1:0] LIM_FAST = CNT_W'(DIV_FAST);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;

  assign conv_done = (cnt_q == lim_q - CNT_W'(1));
  assign pre_done  = (cnt_q == lim_q - CNT_W'(2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= LIM_SLOW;
    end else if (conv_done) begin
      cnt_q <= '0;
      lim_q <= rate_fast ? LIM_FAST : LIM_SLOW;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/adc_code_clip.sv
module adc_code_clip #(
  parameter int SAMPLE_W = 24,
  parameter int CODE_W   = 20
) (
  input  logic [SAMPLE_W-1:0] sample,
  output logic [CODE_W-1:0]   code
);
  generate
    if (SAMPLE_W > CODE_W) begin : g_clip
      localparam logic signed [SAMPLE_W-1:0] POS_LIM =
        SAMPLE_W'((64'd1 << (CODE_W - 1)) - 64'd1);
      localparam logic signed [SAMPLE_W-1:0] NEG_LIM = ~POS_LIM;
      logic signed [SAMPLE_W-1:0] s_val;
      assign s_val = $signed(sample);
      always_comb begin
        if (s_val > POS_LIM)      code = {1'b0, {(CODE_W-1){1'b1}}};
        else if (s_val < NEG_LIM) code = {1'b1, {(CODE_W-1){1'b0}}};
        else                      code = sample[CODE_W-1:0];
      end
    end else begin : g_pass
      assign code = CODE_W'(sample);
    end
  endgenerate
endmodule

// File: rtl/adc_sclk_sync.sv
module adc_sclk_sync #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  output logic sclk_rise
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], sclk};
  end

  assign sclk_rise = sync_q[STAGES-2] & ~sync_q[STAGES-1];
endmodule

// File: rtl/adc_shift_port.sv
module adc_shift_port
  import adc_port_pkg::*;
#(
  parameter int CODE_W = 20
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pre_done,
  input  logic                       conv_done,
  input  logic [CODE_W-1:0]          code,
  input  logic                       sclk_rise,
  output logic                       dout,
  output logic [$clog2(CODE_W+1)-1:0] bit_cnt
);
  localparam int BC_W = $clog2(CODE_W + 1);
  localparam logic [BC_W-1:0] LAST = BC_W'(CODE_W);

  port_state_t       state_q;
  logic [CODE_W-1:0] sreg_q;
  logic [BC_W-1:0]   cnt_q;
  logic              dout_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_IDLE;
      sreg_q  <= '0;
      cnt_q   <= '0;
      dout_q  <= 1'b1;
    end else if (conv_done) begin
      state_q <= PS_READY;
      sreg_q  <= code;
      cnt_q   <= '0;
      dout_q  <= 1'b0;
    end else if (pre_done) begin
      state_q <= PS_IDLE;
      dout_q  <= 1'b1;
    end else if (sclk_rise && state_q != PS_IDLE) begin
      if (cnt_q == LAST) begin
        state_q <= PS_IDLE;
        dout_q  <= 1'b1;
      end else begin
        state_q <= PS_SHIFT;
        dout_q  <= sreg_q[CODE_W-1];
        sreg_q  <= {sreg_q[CODE_W-2:0], 1'b1};
        cnt_q   <= cnt_q + BC_W'(1);
      end
    end
  end

  assign dout    = dout_q;
  assign bit_cnt = cnt_q;
endmodule

// File: rtl/adc_serial_port_model.sv
module adc_serial_port_model #(
  parameter int DIV_SLOW = 491520,
  parameter int DIV_FAST = 61440,
  parameter int SAMPLE_W = 24,
  parameter int CODE_W   = 20
) (
  input  logic                clk_in,
  input  logic                rst_n,
  input  logic                rate_fast,
  input  logic [SAMPLE_W-1:0] sample_in,
  input  logic                sclk,
  output logic                dout_rdy
);
  localparam int BC_W = $clog2(CODE_W + 1);

  logic              pre_done;
  logic              conv_done;
  logic              sclk_rise;
  logic [CODE_W-1:0] clip_code;
  logic [BC_W-1:0]   shift_cnt;

  adc_rate_timer #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_timer (
    .clk(clk_in), .rst_n(rst_n), .rate_fast(rate_fast),
    .pre_done(pre_done), .conv_done(conv_done)
  );

  adc_code_clip #(.SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W)) u_clip (
    .sample(sample_in), .code(clip_code)
  );

  adc_sclk_sync #(.STAGES(3)) u_sync (
    .clk(clk_in), .rst_n(rst_n), .sclk(sclk), .sclk_rise(sclk_rise)
  );

  adc_shift_port #(.CODE_W(CODE_W)) u_shift (
    .clk(clk_in), .rst_n(rst_n), .pre_done(pre_done), .conv_done(conv_done),
    .code(clip_code), .sclk_rise(sclk_rise), .dout(dout_rdy), .bit_cnt(shift_cnt)
  );
endmodule

// File: rtl/adc_port_checker.sv
module adc_port_checker #(
  parameter int DIV_SLOW = 491520,
  parameter int DIV_FAST = 61440,
  parameter int SAMPLE_W = 24,
  parameter int CODE_W   = 20,
  parameter int BC_W     = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic [SAMPLE_W-1:0] sample_in,
  input logic                dout_rdy,
  input logic                pre_done,
  input logic                conv_done,
  input logic                sclk_rise,
  input logic [CODE_W-1:0]   clip_code,
  input logic [BC_W-1:0]     shift_cnt
);
  localparam logic signed [SAMPLE_W-1:0] POS_LIM =
    SAMPLE_W'((64'd1 << (CODE_W - 1)) - 64'd1);
  localparam logic signed [SAMPLE_W-1:0] NEG_LIM = ~POS_LIM;

  int unsigned gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         gap_q <= 1;
    else if (conv_done) gap_q <= 1;
    else                gap_q <= gap_q + 1;
  end

  p_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> (gap_q == DIV_SLOW || gap_q == DIV_FAST));

  p_high_before_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> dout_rdy);

  p_ready_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> !dout_rdy);

  p_quiet_pin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_rise && !pre_done && !conv_done) |=> $stable(dout_rdy));

  p_trailing_ones_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_cnt == BC_W'(CODE_W) && sclk_rise && !pre_done && !conv_done) |=> dout_rdy);

  p_clip_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(sample_in) > POS_LIM) |-> clip_code == {1'b0, {(CODE_W-1){1'b1}}});

  p_clip_neg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(sample_in) < NEG_LIM) |-> clip_code == {1'b1, {(CODE_W-1){1'b0}}});
endmodule

bind adc_serial_port_model adc_port_checker #(
  .DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST), .SAMPLE_W(SAMPLE_W),
  .CODE_W(CODE_W), .BC_W(BC_W)
) u_checker (
  .clk(clk_in), .rst_n(rst_n), .sample_in(sample_in), .dout_rdy(dout_rdy),
  .pre_done(pre_done), .conv_done(conv_done), .sclk_rise(sclk_rise),
  .clip_code(clip_code), .shift_cnt(shift_cnt)
);

// File: tb/adc_serial_port_model_bench.sv
module adc_serial_port_model_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_SLOW   = 400;
  localparam int DIV_FAST   = 256;
  localparam int SAMPLE_W   = 24;
  localparam int CODE_W     = 20;
  localparam int NVEC       = 11;

  localparam logic [SAMPLE_W-1:0] VEC_IN [NVEC] = '{
    24'sd0, 24'sd1, -24'sd1, 24'sd524287, 24'sd524288, 24'sd8388607,
    -24'sd524288, -24'sd524289, -24'sd8388608, 24'sd74565, -24'sd74565
  };
  localparam logic [CODE_W-1:0] VEC_EXP [NVEC] = '{
    20'h00000, 20'h00001, 20'hFFFFF, 20'h7FFFF, 20'h7FFFF, 20'h7FFFF,
    20'h80000, 20'h80000, 20'h80000, 20'h12345, 20'hEDCBB
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rate_fast = 1'b0;
  logic [SAMPLE_W-1:0] sample_in = '0;
  logic sclk = 1'b0;
  logic dout_rdy;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_serial_port_model #(
    .DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST), .SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W)
  ) u_adc_serial_port_model (
    .clk_in(clk), .rst_n(rst_n), .rate_fast(rate_fast),
    .sample_in(sample_in), .sclk(sclk), .dout_rdy(dout_rdy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_fall(output int per, output int lows);
    logic prev;
    prev = dout_rdy;
    per = 0;
    lows = 0;
    forever begin
      @(negedge clk);
      per++;
      if (!dout_rdy) lows++;
      if (prev && !dout_rdy) break;
      prev = dout_rdy;
      if (per > 3000) begin
        per = -1;
        break;
      end
    end
  endtask

  task automatic sclk_pulse(output logic v);
    sclk = 1'b1;
    repeat (3) @(negedge clk);
    v = dout_rdy;
    @(negedge clk);
    sclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic read_frame(output logic [CODE_W-1:0] code, output logic [5:0] tail);
    logic v;
    for (int b = 0; b < CODE_W + 6; b++) begin
      sclk_pulse(v);
      if (b < CODE_W) code[CODE_W-1-b] = v;
      else            tail[b-CODE_W] = v;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    int per;
    int lows;
    logic [CODE_W-1:0] code;
    logic [5:0] tail;

    repeat (5) @(negedge clk);
    check(dout_rdy === 1'b1, "R1 pin high in reset", dout_rdy, 1);
    rst_n = 1'b1;

    wait_fall(per, lows);
    check(per == DIV_SLOW, "R1 first period", per, DIV_SLOW);
    wait_fall(per, lows);
    check(per == DIV_SLOW, "R2 slow period", per, DIV_SLOW);

    rate_fast = 1'b1;
    wait_fall(per, lows);
    check(per == DIV_SLOW, "R4 change deferred", per, DIV_SLOW);
    wait_fall(per, lows);
    check(per == DIV_FAST, "R3 fast period", per, DIV_FAST);

    for (int i = 0; i < NVEC; i++) begin
      sample_in = VEC_IN[i];
      wait_fall(per, lows);
      read_frame(code, tail);
      check(code == VEC_EXP[i], "R5/R6/R7/R8 code", code, VEC_EXP[i]);
      check(tail == 6'h3F, "R9 trailing ones", tail, 6'h3F);
    end

    sample_in = 24'sd300000;
    wait_fall(per, lows);
    lows = 0;
    repeat (20) begin
      @(negedge clk);
      if (dout_rdy) lows++;
    end
    check(lows == 0, "R11 ready held low", lows, 0);

    sample_in = -24'sd2;
    wait_fall(per, lows);
    check(per == DIV_FAST - 20, "R10 overwrite timing", per, DIV_FAST - 20);
    check(lows == per - 1, "R10 one high cycle", lows, per - 1);
    read_frame(code, tail);
    check(code == 20'hFFFFE, "R10 newer code read", code, 20'hFFFFE);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule